// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter with Indexed Grant

This block arbitrates among a parameterised number of requesters that share one resource. Every clock edge it samples a request vector and issues a registered grant, given as a binary requester number, together with a flag that says whether that grant is live. Priority rotates each cycle. The search for the next winner starts one position above the requester that holds the grant now and wraps past the top of the vector. As a result, the holder gives up the grant whenever any other requester is waiting, even if the holder is still asserting its own request.

When nobody requests, the flag drops on the next edge. The grant register keeps its last number, and the next search starts from that retained value. Two implementations of the search are available through a parameter. One is a circular scan. The other splits the vector into the part above the holder and a fallback over the whole vector, and feeds both parts to priority encoders. The two give identical results.

Top module: `rr_index_arbiter`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge sets `grant_o` to 0 and `valid_o` to 0 after that edge.
- R2: `grant_o` is `max(1, ceil(log2(N_REQ)))` bits wide. Whenever `valid_o` is 1, `grant_o` is below `N_REQ`, including for counts that are not powers of two.
- R3: When at least one request bit is set, the new grant is the first set bit of `req_i` found when checking indices g+1, g+2, … modulo `N_REQ`, where g is the grant held before the edge. The granted requester had its bit set, and no set bit between the old and new grant is skipped.
- R4: If the current holder is the only requester, the search wraps around to it and it keeps the grant.
- R5: With `req_i` all zero at an edge, `valid_o` is 0 after that edge and `grant_o` keeps its value. The next search starts from this retained value.
- R6: With any request bit set at an edge, `valid_o` is 1 after that edge. Both outputs change only at the edge after the requests are sampled.
- R7: With `N_REQ` = 1, `grant_o` is always 0 and `valid_o` equals the request bit sampled at the previous edge.
- R8: The search wraps past index `N_REQ`-1 to index 0. For example, with three requesters, grant 2 and requests 0b010 give grant 1, and grant 1 and requests 0b011 give grant 0 (bit i of `req_i` is requester i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_REQ | Request vector, bit i belongs to requester i |
| grant_o | output | IDX_W | Registered binary number of the granted requester |
| valid_o | output | 1 | Registered flag, high when a requester was granted at the last edge |

## Verification
The checker assumes that `req_i` is a clean, known, synchronous value at every rising edge. It also assumes that `rst` is applied at least once before arbitration matters, since the range and no-skip properties depend on the grant register starting from a legal index. The bench changes requests and reset only on falling edges, from fully defined values, and holds reset for two edges at start-up. It then runs directed sequences and a long stretch of dense and sparse random vectors against a behavioural model, covering counts of one, three and five and both search implementations.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

   // Implementation choice for the rotating search.
   typedef enum logic [0:0] {
      SEARCH_SCAN  = 1'b0,   // circular scan from holder+1
      SEARCH_SPLIT = 1'b1    // masked upper half, then full-vector fallback
   } search_e;

   // Index width: ceil(log2(n)), never less than one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rr_first_set.sv
// Lowest-set-bit locator: reports whether any bit is set and the index of the lowest one.
module rr_first_set #(
   parameter int W  = 4,
   parameter int IW = 2
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   if (W < 1) begin : g_bad_w
      $error("rr_first_set: W must be at least 1");
   end
   if ((1 << IW) < W) begin : g_bad_iw
      $error("rr_first_set: IW too narrow for W");
   end

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/rr_next_search.sv
// Rotating search: first set request strictly after cur, wrapping, ending at cur itself.
module rr_next_search
   import rr_arb_pkg::*;
#(
   parameter int      N      = 3,
   parameter int      IW     = 2,
   parameter search_e STYLE  = SEARCH_SPLIT
) (
   input  logic [IW-1:0] cur,
   input  logic [N-1:0]  req,
   output logic          hit,
   output logic [IW-1:0] nxt
);

   if (N < 1) begin : g_bad_n
      $error("rr_next_search: N must be at least 1");
   end

   if (STYLE == SEARCH_SPLIT) begin : g_split
      logic [N-1:0]  above;
      logic [N-1:0]  req_hi;
      logic          hi_found;
      logic [IW-1:0] hi_idx;
      logic          all_found;
      logic [IW-1:0] all_idx;

      for (genvar i = 0; i < N; i++) begin : g_mask
         assign above[i] = (IW'(i) > cur);
      end
      assign req_hi = req & above;

      rr_first_set #(.W(N), .IW(IW)) u_hi (
         .vec   (req_hi),
         .found (hi_found),
         .idx   (hi_idx)
      );
      rr_first_set #(.W(N), .IW(IW)) u_all (
         .vec   (req),
         .found (all_found),
         .idx   (all_idx)
      );

      assign hit = all_found;
      assign nxt = hi_found ? hi_idx : all_idx;
   end else begin : g_scan
      logic [IW-1:0] pos;
      always_comb begin
         hit = 1'b0;
         nxt = '0;
         pos = '0;
         // Descending distance so the nearest hit is written last.
         for (int k = N; k >= 1; k--) begin
            pos = IW'((int'(cur) + k) % N);
            if (req[pos]) begin
               hit = 1'b1;
               nxt = pos;
            end
         end
      end
   end

endmodule

// File: rtl/rr_grant_reg.sv
// Output state: grant number and live flag, with hold on idle.
module rr_grant_reg #(
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hit,
   input  logic [IW-1:0] nxt,
   output logic [IW-1:0] grant,
   output logic          valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         grant <= '0;
         valid <= 1'b0;
      end else begin
         valid <= hit;
         if (hit) grant <= nxt;
      end
   end

endmodule

// File: rtl/rr_index_arbiter.sv
module rr_index_arbiter
   import rr_arb_pkg::*;
#(
   parameter int      N_REQ  = 3,
   parameter search_e SEARCH = SEARCH_SPLIT,
   localparam int     IDX_W  = idx_width(N_REQ)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_REQ-1:0] req_i,
   output logic [IDX_W-1:0] grant_o,
   output logic             valid_o
);

   if (N_REQ < 1) begin : g_bad_count
      $error("rr_index_arbiter: N_REQ must be at least 1");
   end

   logic             srch_hit;
   logic [IDX_W-1:0] srch_idx;

   if (N_REQ == 1) begin : g_single
      // One requester: the only legal number is 0.
      assign srch_hit = req_i[0];
      assign srch_idx = '0;
   end else begin : g_multi
      rr_next_search #(.N(N_REQ), .IW(IDX_W), .STYLE(SEARCH)) u_search (
         .cur (grant_o),
         .req (req_i),
         .hit (srch_hit),
         .nxt (srch_idx)
      );
   end

   rr_grant_reg #(.IW(IDX_W)) u_state (
      .clk   (clk),
      .rst   (rst),
      .hit   (srch_hit),
      .nxt   (srch_idx),
      .grant (grant_o),
      .valid (valid_o)
   );

endmodule

// File: rtl/rr_index_arbiter_chk.sv
module rr_index_arbiter_chk #(
   parameter int N_REQ = 3,
   parameter int IW    = 2
) (
   input logic             clk,
   input logic             rst,
   input logic [N_REQ-1:0] req,
   input logic [IW-1:0]    grant,
   input logic             valid
);

   logic [N_REQ-1:0] req_q;
   logic [IW-1:0]    grant_q;
   logic             skipped;
   logic             past_mid;
   logic [IW-1:0]    pos;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q   <= '0;
         grant_q <= '0;
      end else begin
         req_q   <= req;
         grant_q <= grant;
      end
   end

   // A set bit strictly between the previous and current grant (circularly) was passed over.
   always_comb begin
      skipped  = 1'b0;
      past_mid = 1'b0;
      pos      = '0;
      for (int k = 1; k < N_REQ; k++) begin
         pos = IW'((int'(grant_q) + k) % N_REQ);
         if (pos == grant) past_mid = 1'b1;
         if (!past_mid && req_q[pos]) skipped = 1'b1;
      end
   end

   // R1
   a_r1_reset: assert property (@(posedge clk) rst |=> (grant == '0 && !valid));

   // R2
   a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
      valid |-> (int'(grant) < N_REQ));

   // R3
   a_r3_holder_requested: assert property (@(posedge clk) disable iff (rst)
      valid |-> req_q[grant]);

   // R3
   a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
      valid |-> !skipped);

   // R4
   a_r4_sole_keeps: assert property (@(posedge clk) disable iff (rst)
      (valid && $countones(req) == 1 && req[grant]) |=> (valid && $stable(grant)));

   // R5
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |=> (!valid && $stable(grant)));

   // R6
   a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
      (req != '0) |=> valid);

endmodule

bind rr_index_arbiter rr_index_arbiter_chk #(.N_REQ(N_REQ), .IW(IDX_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .req   (req_i),
   .grant (grant_o),
   .valid (valid_o)
);

// File: tb/rr_index_arbiter_tb_top.sv
`timescale 1ns/1ps
module rr_index_arbiter_tb_top;
   import rr_arb_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] r3  = '0;
   logic       r1  = 1'b0;
   logic [4:0] r5  = '0;

   logic [1:0] g3;  logic v3;
   logic [0:0] g1;  logic v1;
   logic [2:0] g5a; logic v5a;
   logic [2:0] g5b; logic v5b;

   int checks   = 0;
   int failures = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   rr_index_arbiter #(.N_REQ(3), .SEARCH(SEARCH_SPLIT)) dut_i (
      .clk(clk), .rst(rst), .req_i(r3), .grant_o(g3), .valid_o(v3));
   rr_index_arbiter #(.N_REQ(1), .SEARCH(SEARCH_SCAN)) dut1_i (
      .clk(clk), .rst(rst), .req_i(r1), .grant_o(g1), .valid_o(v1));
   rr_index_arbiter #(.N_REQ(5), .SEARCH(SEARCH_SCAN)) dut5_i (
      .clk(clk), .rst(rst), .req_i(r5), .grant_o(g5a), .valid_o(v5a));
   rr_index_arbiter #(.N_REQ(5), .SEARCH(SEARCH_SPLIT)) dut5s_i (
      .clk(clk), .rst(rst), .req_i(r5), .grant_o(g5b), .valid_o(v5b));

   // Behavioural reference: one entry per instance.
   int sizes[4] = '{3, 1, 5, 5};
   int m_g[4]   = '{0, 0, 0, 0};
   bit m_v[4]   = '{0, 0, 0, 0};

   function automatic logic [4:0] req_of(int d);
      case (d)
         0: return {2'b00, r3};
         1: return {4'b0000, r1};
         default: return r5;
      endcase
   endfunction

   function automatic int out_g(int d);
      case (d)
         0: return int'(g3);
         1: return int'(g1);
         2: return int'(g5a);
         default: return int'(g5b);
      endcase
   endfunction

   function automatic bit out_v(int d);
      case (d)
         0: return v3;
         1: return v1;
         2: return v5a;
         default: return v5b;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int d = 0; d < 4; d++) begin
         if (rst) begin
            m_g[d] = 0;
            m_v[d] = 0;
         end else begin
            logic [4:0] rq;
            int found;
            rq    = req_of(d);
            found = -1;
            for (int k = 1; k <= sizes[d]; k++) begin
               int p;
               p = (m_g[d] + k) % sizes[d];
               if (found < 0 && rq[p]) found = p;
            end
            m_v[d] = (found >= 0);
            if (found >= 0) m_g[d] = found;
         end
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model on the falling edge.
   always @(negedge clk) begin
      for (int d = 0; d < 4; d++) begin
         check(phase, $sformatf("model valid dut%0d", d), int'(out_v(d)), int'(m_v[d]));
         check(phase, $sformatf("model grant dut%0d", d), out_g(d), m_g[d]);
      end
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // Drive on a falling edge, then look at the next falling edge.
   task automatic step3(input logic [2:0] rq, input int eg, input bit ev, input string tag);
      r3 = rq;
      @(negedge clk);
      check(tag, "valid n3", int'(v3), int'(ev));
      check(tag, "grant n3", int'(g3), eg);
   endtask

   task automatic step5(input logic [4:0] rq, input int eg, input bit ev, input string tag);
      r5 = rq;
      @(negedge clk);
      check(tag, "valid n5 scan", int'(v5a), int'(ev));
      check(tag, "grant n5 scan", int'(g5a), eg);
      check(tag, "valid n5 split", int'(v5b), int'(ev));
      check(tag, "grant n5 split", int'(g5b), eg);
   endtask

   task automatic step1(input logic rq, input string tag);
      r1 = rq;
      @(negedge clk);
      check(tag, "valid n1", int'(v1), int'(rq));
      check(tag, "grant n1", int'(g1), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      // R1: reset state
      phase = "R1";
      repeat (2) @(negedge clk);
      check("R1", "reset valid", int'(v3), 0);
      check("R1", "reset grant", int'(g3), 0);
      check("R1", "reset valid n5", int'(v5a), 0);
      rst = 1'b0;

      // R3 / R4 / R8 / R5 directed run on three requesters
      phase = "R3";
      step3(3'b111, 1, 1, "R3");
      step3(3'b110, 2, 1, "R3");
      step3(3'b010, 1, 1, "R8");
      step3(3'b011, 0, 1, "R8");
      step3(3'b001, 0, 1, "R4");
      step3(3'b101, 2, 1, "R3");
      step3(3'b100, 2, 1, "R4");
      step3(3'b000, 2, 0, "R5");
      step3(3'b001, 0, 1, "R6");
      step3(3'b011, 1, 1, "R3");

      // R7: single requester
      phase = "R7";
      step1(1'b0, "R7");
      step1(1'b1, "R7");
      step1(1'b1, "R7");
      step1(1'b0, "R7");
      step1(1'b1, "R7");

      // R5 / R2 / R8 on five requesters
      phase = "R5";
      step5(5'b00100, 2, 1, "R6");
      step5(5'b00000, 2, 0, "R5");
      step5(5'b00000, 2, 0, "R5");
      step5(5'b11111, 3, 1, "R5");
      step5(5'b00111, 0, 1, "R8");
      step5(5'b10000, 4, 1, "R2");
      step5(5'b10000, 4, 1, "R4");
      step5(5'b00010, 1, 1, "R8");

      // Mid-run reset returns to the reset state (R1)
      phase = "R1";
      rst = 1'b1;
      r3 = 3'b111;
      r5 = 5'b11111;
      @(negedge clk);
      check("R1", "mid reset valid", int'(v3), 0);
      check("R1", "mid reset grant", int'(g5a), 0);
      rst = 1'b0;

      // Random stretch: model compare; range bound checked every cycle (R2)
      phase = "R3";
      for (int c = 0; c < 2000; c++) begin
         if (c < 1000) begin
            r3 = 3'($urandom);
            r5 = 5'($urandom);
         end else begin
            r3 = 3'($urandom) & 3'($urandom);
            r5 = 5'($urandom) & 5'($urandom) & 5'($urandom);
         end
         r1 = 1'($urandom);
         @(negedge clk);
         check("R2", "grant below count n5", int'(int'(g5a) < 5), 1);
         check("R2", "grant below count n3", int'(int'(g3) < 3), 1);
      end

      report();
      $finish;
   end

endmodule